// File: doc/BRIEF.md
# Spawn-Join Thread Dispatcher

The dispatcher moves a many-threaded processor between serial and parallel execution. While in serial mode only the master controller runs. The master posts a spawn carrying an inclusive pair of thread indices, a low bound and a high bound. Every index in that pair becomes one virtual thread. The dispatcher then enters parallel mode and hands out thread IDs to a set of thread control units (TCUs) on demand.

IDs come from one shared counter that is advanced by an atomic fetch-and-increment. They are not split among the TCUs in advance, so a TCU that finishes early simply takes more threads, and there can be far more threads than TCUs. A TCU asks for work by raising its request; a raised request also means its previous thread has finished. When the counter has passed the high bound, a requester is answered with "no work" and counts as having reached join. Once every TCU has joined, the dispatcher returns to serial mode and pulses a done signal to the master. Ending one spawn and issuing another is the way to force an ordering between two groups of threads.

Top module: `spawn_dispatch`

## Requirements
- R1: After a synchronous active-low reset the block is in serial mode, with `spawn_busy`, `spawn_done` and every `tcu_grant` bit low.
- R2: In serial mode, a `spawn_req` with `spawn_lo <= spawn_hi` raises `spawn_busy` in the following cycle.
- R3: While `spawn_busy` is high, `spawn_req` is ignored. No ID from its bounds is ever handed out, and the running spawn keeps its bounds.
- R4: In parallel mode, an eligible TCU whose request is high at a clock edge sees `tcu_grant` high for exactly the next cycle, with its ID on its slice of `tcu_id` (bits i*ID_W upward for TCU i).
- R5: All TCUs that request at the same edge are served at that edge with consecutive IDs. The lowest TCU index gets the smallest ID, and the shared counter advances by the number served.
- R6: A grant whose ID exceeds the high bound has `tcu_work` low. That TCU is then joined, and its requests are ignored until the next spawn.
- R7: Across one spawn, every index from low to high is granted with `tcu_work` high exactly once, even when the threads outnumber the TCUs.
- R8: One cycle after the last TCU joins, `spawn_busy` falls and `spawn_done` is high for exactly one cycle.
- R9: A spawn with `spawn_lo > spawn_hi` leaves the block in serial mode, dispatches no thread, and pulses `spawn_done` in the next cycle.
- R10: A request held high during the cycle its grant is shown is not served at that edge, so one TCU is never granted in two consecutive cycles.
- R11: A spawn issued after the previous one completes restarts the counter at its own low bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spawn_req | input | 1 | Master posts a spawn (single cycle) |
| spawn_lo | input | ID_W | First thread index of the spawn |
| spawn_hi | input | ID_W | Last thread index of the spawn (inclusive) |
| spawn_busy | output | 1 | High while in parallel mode |
| spawn_done | output | 1 | One-cycle pulse when the spawn has fully joined |
| tcu_req | input | NUM_TCU | Per-TCU request for a next thread ID |
| tcu_grant | output | NUM_TCU | Per-TCU one-cycle answer to a request |
| tcu_work | output | NUM_TCU | Per-TCU: granted ID is valid work (low means go to join) |
| tcu_id | output | NUM_TCU*ID_W | Per-TCU granted ID, TCU i in bits i*ID_W upward |

## Verification
The bench builds the block with four TCUs and 10-bit IDs. With these values, ranges of sixteen threads run several threads per TCU, and a three-thread range makes the fourth of four simultaneous requesters receive the no-work answer in the same cycle as the others get real IDs. A behavioural model driven by the same inputs predicts mode, done, grants, work flags and IDs on every cycle. Directed phases add a held request to expose the one-cycle gap, a spawn posted during parallel mode, an empty range, and a back-to-back pair of spawns.

// File: rtl/sj_pkg.sv
// Shared types for the spawn-join dispatcher.
// Assumes nothing beyond a two-valued mode.
package sj_pkg;
    typedef enum logic {
        MODE_SERIAL   = 1'b0,
        MODE_PARALLEL = 1'b1
    } sj_mode_e;
endpackage

// File: rtl/sj_rank.sv
// Prefix counter: for every set bit of the eligibility vector, gives how many
// lower-index bits are set, plus the total. Purely combinational.
// Assumes RW can hold NUM_TCU.
module sj_rank #(
    parameter int NUM_TCU = 8,
    parameter int RW      = $clog2(NUM_TCU + 1)
) (
    input  logic [NUM_TCU-1:0]         elig,
    output logic [NUM_TCU-1:0][RW-1:0] rank,
    output logic [RW-1:0]              total
);
    // Running count in index order sets the priority.
    always_comb begin
        logic [RW-1:0] acc;
        acc = '0;
        for (int i = 0; i < NUM_TCU; i++) begin
            rank[i] = acc;
            acc     = acc + RW'(elig[i]);
        end
        total = acc;
    end
endmodule

// File: rtl/sj_id_alloc.sv
// Fetch-and-increment allocator: served requesters get base+rank in ascending
// index order; a slot beyond the high bound is flagged as no work.
// Assumes CNT_W is wide enough for base + NUM_TCU without wrap.
module sj_id_alloc #(
    parameter int NUM_TCU = 8,
    parameter int ID_W    = 16,
    parameter int RW      = $clog2(NUM_TCU + 1),
    parameter int CNT_W   = ID_W + RW + 1
) (
    input  logic [CNT_W-1:0]             base,
    input  logic [ID_W-1:0]              hi,
    input  logic [NUM_TCU-1:0]           elig,
    output logic [NUM_TCU-1:0][ID_W-1:0] slot_id,
    output logic [NUM_TCU-1:0]           slot_work,
    output logic [CNT_W-1:0]             next_base
);
    logic [NUM_TCU-1:0][RW-1:0] rank;
    logic [RW-1:0]              total;

    sj_rank #(.NUM_TCU(NUM_TCU), .RW(RW)) u_rank (
        .elig  (elig),
        .rank  (rank),
        .total (total)
    );

    // Counter advance by the number served this cycle.
    assign next_base = base + CNT_W'(total);

    for (genvar i = 0; i < NUM_TCU; i++) begin : g_slot
        logic [CNT_W-1:0] slot;
        // Slot for TCU i and its range test.
        assign slot         = base + CNT_W'(rank[i]);
        assign slot_id[i]   = slot[ID_W-1:0];
        assign slot_work[i] = (slot <= CNT_W'(hi));
    end
endmodule

// File: rtl/sj_join_track.sv
// Remembers which TCUs have reached join during the current spawn.
// Assumes clear and set never target one TCU in the same cycle.
module sj_join_track #(
    parameter int NUM_TCU = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic [NUM_TCU-1:0] set,
    output logic [NUM_TCU-1:0] joined,
    output logic               all_joined
);
    // Join flags: cleared on a new spawn, set on a no-work grant.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) joined <= '0;
        else                 joined <= joined | set;
    end

    assign all_joined = &joined;

    // R6
    no_rejoin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set & joined) == '0);
endmodule

// File: rtl/spawn_dispatch.sv
// Spawn-join dispatcher top. Serial mode waits for a spawn; parallel mode
// serves TCU requests from a shared counter until every TCU has joined.
// Assumes a TCU keeps its request high until it sees its grant.
module spawn_dispatch
    import sj_pkg::*;
#(
    parameter int NUM_TCU = 8,
    parameter int ID_W    = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      spawn_req,
    input  logic [ID_W-1:0]           spawn_lo,
    input  logic [ID_W-1:0]           spawn_hi,
    output logic                      spawn_busy,
    output logic                      spawn_done,
    input  logic [NUM_TCU-1:0]        tcu_req,
    output logic [NUM_TCU-1:0]        tcu_grant,
    output logic [NUM_TCU-1:0]        tcu_work,
    output logic [NUM_TCU*ID_W-1:0]   tcu_id
);
    localparam int RW    = $clog2(NUM_TCU + 1);
    localparam int CNT_W = ID_W + RW + 1;

    sj_mode_e                    mode_q;
    logic [CNT_W-1:0]            cnt_q;
    logic [ID_W-1:0]             hi_q;
    logic [NUM_TCU-1:0]          grant_q;
    logic [NUM_TCU-1:0]          work_q;
    logic [NUM_TCU-1:0][ID_W-1:0] id_q;
    logic                        done_q;

    logic [NUM_TCU-1:0]          joined;
    logic                        all_joined;
    logic [NUM_TCU-1:0]          elig;
    logic [NUM_TCU-1:0][ID_W-1:0] slot_id;
    logic [NUM_TCU-1:0]          slot_work;
    logic [CNT_W-1:0]            next_base;
    logic                        accept;
    logic                        in_par;

    assign in_par = (mode_q == MODE_PARALLEL);
    // A spawn with a non-empty range starts parallel mode.
    assign accept = !in_par && spawn_req && (spawn_lo <= spawn_hi);
    // Requesters served now: not joined, not showing a grant this cycle.
    assign elig   = in_par ? (tcu_req & ~grant_q & ~joined) : '0;

    sj_id_alloc #(.NUM_TCU(NUM_TCU), .ID_W(ID_W), .RW(RW), .CNT_W(CNT_W)) u_alloc (
        .base      (cnt_q),
        .hi        (hi_q),
        .elig      (elig),
        .slot_id   (slot_id),
        .slot_work (slot_work),
        .next_base (next_base)
    );

    sj_join_track #(.NUM_TCU(NUM_TCU)) u_join (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .set        (elig & ~slot_work),
        .joined     (joined),
        .all_joined (all_joined)
    );

    // Mode, counter, done pulse and registered grants.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_SERIAL;
            cnt_q   <= '0;
            hi_q    <= '0;
            grant_q <= '0;
            work_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            grant_q <= '0;
            work_q  <= '0;
            if (!in_par) begin
                if (accept) begin
                    mode_q <= MODE_PARALLEL;
                    cnt_q  <= CNT_W'(spawn_lo);
                    hi_q   <= spawn_hi;
                end else if (spawn_req) begin
                    done_q <= 1'b1;
                end
            end else if (all_joined) begin
                mode_q <= MODE_SERIAL;
                done_q <= 1'b1;
            end else begin
                grant_q <= elig;
                work_q  <= elig & slot_work;
                cnt_q   <= next_base;
            end
        end
    end

    // Per-TCU ID holding registers, loaded when served.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q <= '0;
        end else begin
            for (int i = 0; i < NUM_TCU; i++)
                if (elig[i]) id_q[i] <= slot_id[i];
        end
    end

    for (genvar i = 0; i < NUM_TCU; i++) begin : g_out
        assign tcu_id[i*ID_W +: ID_W] = id_q[i];

        // R4
        grant_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tcu_grant[i] |-> $past(tcu_req[i]));
        // R10
        no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tcu_grant[i] |=> !tcu_grant[i]);
        // R6
        work_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tcu_grant[i] && tcu_work[i]) |-> (tcu_id[i*ID_W +: ID_W] <= hi_q));
    end

    assign spawn_busy = in_par;
    assign spawn_done = done_q;
    assign tcu_grant  = grant_q;
    assign tcu_work   = work_q;

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spawn_done |=> !spawn_done);
    // R8
    leave_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spawn_busy) |-> spawn_done);
    // R1
    serial_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spawn_busy |-> (tcu_grant == '0));
    // R3
    hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spawn_busy && $past(spawn_busy)) |-> $stable(hi_q));
endmodule

// File: tb/sim_spawn_dispatch.sv
module sim_spawn_dispatch;
    localparam int N    = 4;
    localparam int ID_W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spawn_req = 1'b0;
    logic [ID_W-1:0] spawn_lo = '0, spawn_hi = '0;
    logic spawn_busy, spawn_done;
    logic [N-1:0] tcu_req = '0;
    logic [N-1:0] tcu_grant, tcu_work;
    logic [N*ID_W-1:0] tcu_id;

    always #2.5 clk = ~clk;

    spawn_dispatch #(.NUM_TCU(N), .ID_W(ID_W)) u0 (
        .clk(clk), .rst_n(rst_n), .spawn_req(spawn_req), .spawn_lo(spawn_lo),
        .spawn_hi(spawn_hi), .spawn_busy(spawn_busy), .spawn_done(spawn_done),
        .tcu_req(tcu_req), .tcu_grant(tcu_grant), .tcu_work(tcu_work), .tcu_id(tcu_id)
    );

    int tests = 0, fails = 0, cycles = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    bit m_par, m_done;
    bit [N-1:0] m_grant, m_work, m_joined;
    int m_id [N];
    int m_cnt, m_hi;

    always @(posedge clk) begin : model
        int k;
        bit [N-1:0] elig, old_joined;
        if (!rst_n) begin
            m_par = 0; m_done = 0; m_grant = 0; m_work = 0; m_joined = 0;
            m_cnt = 0; m_hi = 0;
            for (int i = 0; i < N; i++) m_id[i] = 0;
        end else begin
            old_joined = m_joined;
            elig = m_par ? (tcu_req & ~m_grant & ~m_joined) : '0;
            m_done = 0; m_grant = 0; m_work = 0;
            if (!m_par) begin
                if (spawn_req) begin
                    if (spawn_lo <= spawn_hi) begin
                        m_par = 1; m_cnt = int'(spawn_lo); m_hi = int'(spawn_hi); m_joined = 0;
                    end else m_done = 1;
                end
            end else if (&old_joined) begin
                m_par = 0; m_done = 1;
            end else begin
                k = 0;
                for (int i = 0; i < N; i++) if (elig[i]) begin
                    m_grant[i] = 1;
                    m_id[i] = (m_cnt + k) % (1 << ID_W);
                    m_work[i] = (m_cnt + k) <= m_hi;
                    if (!m_work[i]) m_joined[i] = 1;
                    k++;
                end
                m_cnt += k;
            end
        end
    end

    // Cycle-by-cycle comparison against the model.
    bit compare_on = 0;
    always @(negedge clk) if (compare_on) begin
        check(spawn_busy == m_par, "R2 busy", spawn_busy, m_par);
        check(spawn_done == m_done, "R8 done", spawn_done, m_done);
        check(tcu_grant == m_grant, "R4 grant", tcu_grant, m_grant);
        check(tcu_work == m_work, "R6 work", tcu_work, m_work);
        for (int i = 0; i < N; i++)
            if (m_grant[i])
                check(int'(tcu_id[i*ID_W +: ID_W]) == m_id[i], "R5 id",
                      tcu_id[i*ID_W +: ID_W], m_id[i]);
    end

    // ---------------- TCU behaviour ----------------
    bit [N-1:0] en = 0, hold = 0, stopped = 0, got_first = 0;
    int busy_cnt [N];
    int first_id [N];
    bit first_work [N];
    int seen [1024];
    int work_total = 0, back_to_back = 0;
    bit [N-1:0] prev_grant = 0;

    always @(negedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (tcu_grant[i] && prev_grant[i]) back_to_back++;
            if (!en[i]) tcu_req[i] = 0;
            else if (tcu_req[i] && tcu_grant[i]) begin
                if (!got_first[i]) begin
                    got_first[i] = 1; first_id[i] = int'(tcu_id[i*ID_W +: ID_W]);
                    first_work[i] = tcu_work[i];
                end
                if (tcu_work[i]) begin
                    seen[tcu_id[i*ID_W +: ID_W]]++; work_total++;
                    busy_cnt[i] = (i + int'(tcu_id[i*ID_W +: ID_W])) % 3;
                    if (!hold[i]) tcu_req[i] = 0;
                end else begin
                    stopped[i] = 1; tcu_req[i] = 0;
                end
            end else if (!tcu_req[i] && !stopped[i] && busy_cnt[i] == 0) tcu_req[i] = 1;
            else if (busy_cnt[i] > 0) busy_cnt[i]--;
        end
        prev_grant = tcu_grant;
    end

    task automatic arm(input bit [N-1:0] hold_mask, input int start_delay);
        @(negedge clk);
        en = 0; #0;
        stopped = 0; got_first = 0; hold = hold_mask; work_total = 0; back_to_back = 0;
        for (int i = 0; i < N; i++) busy_cnt[i] = start_delay * i;
        for (int j = 0; j < 1024; j++) seen[j] = 0;
        en = '1;
    endtask

    task automatic spawn(input int lo, input int hi);
        @(negedge clk);
        spawn_req = 1; spawn_lo = ID_W'(lo); spawn_hi = ID_W'(hi);
        @(negedge clk);
        spawn_req = 0;
    endtask

    task automatic wait_done();
        int lim = 0;
        while (!spawn_done && lim < 2000) begin @(negedge clk); lim++; end
        check(spawn_done, "R8 done reached", spawn_done, 1);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++; tests++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check(!spawn_busy && !spawn_done && tcu_grant == 0, "R1 reset",
              {spawn_busy, spawn_done, tcu_grant}, 0);
        compare_on = 1;

        // R7, R3: 16 threads over 4 TCUs, stray spawn while busy
        arm('0, 1);
        spawn(5, 20);
        check(spawn_busy, "R2 busy after spawn", spawn_busy, 1);
        repeat (3) @(negedge clk);
        spawn(600, 700);
        wait_done();
        cnt = 0;
        for (int j = 5; j <= 20; j++) if (seen[j] == 1) cnt++;
        check(cnt == 16 && work_total == 16, "R7 each index once", work_total, 16);
        cnt = 0;
        for (int j = 600; j <= 700; j++) cnt += seen[j];
        check(cnt == 0, "R3 ignored spawn", cnt, 0);
        @(negedge clk);
        check(!spawn_done && !spawn_busy, "R8 single pulse", spawn_done, 0);

        // R5, R6: four simultaneous requests, three threads
        arm('0, 0);
        spawn(100, 102);
        repeat (2) @(negedge clk);
        for (int i = 0; i < 3; i++)
            check(got_first[i] && first_id[i] == 100 + i && first_work[i], "R5 order",
                  first_id[i], 100 + i);
        check(got_first[3] && !first_work[3], "R6 no work", first_work[3], 0);
        wait_done();

        // R9: empty range
        arm('0, 0);
        spawn(10, 3);
        check(spawn_done && !spawn_busy, "R9 empty done", spawn_done, 1);
        check(work_total == 0, "R9 no dispatch", work_total, 0);

        // R10: held request on TCU0
        arm(4'b0001, 2);
        spawn(0, 9);
        wait_done();
        check(back_to_back == 0, "R10 gap", back_to_back, 0);
        check(work_total == 10, "R7 with hold", work_total, 10);

        // R11: back-to-back spawns
        arm('0, 0);
        spawn(30, 33);
        wait_done();
        arm('0, 0);
        spawn(50, 53);
        repeat (2) @(negedge clk);
        check(got_first[0] && first_id[0] == 50, "R11 restart", first_id[0], 50);
        wait_done();

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule